// File: doc/BRIEF.md
# Video Info Packet Generator

This block builds the auxiliary video information packet that a display transmitter sends alongside the picture, and streams it out one byte per handshake. The packet describes the picture to the sink: the colour encoding, the picture shape and the video timing code. The block assembles every field in hardware and computes the integrity byte itself, so the rest of the transmitter only has to forward a finished byte stream.

Sending is paced by a frame-start strobe. A two-bit send mode decides whether a strobe launches a packet: never, once, or on every frame. The configuration inputs are captured when a packet starts and held until it ends, so a packet is always consistent. A strobe that arrives while a packet is still going out is discarded and raises a sticky flag.

Top module: `avi_pkt_gen`

## Requirements
- R1: After a synchronous active-low reset, `tx_valid`, `tx_last` and `overflow` are 0.
- R2: A packet is 17 bytes sent in this order: 0x82, 0x02, 0x0D (header), the check byte, then payload bytes 1 to 13; `tx_last` is 1 on the 17th byte only, and `tx_valid` drops after it is accepted.
- R3: The check byte makes the 8-bit sum of all 17 bytes equal to zero (for colour 0, aspect 2 and code 16 it is 0x25).
- R4: Payload byte 1 has bit 1 set (underscanned), bit 4 set (active format present), bits 6:5 equal to `colour_sel` (0 RGB, 1 YCbCr 4:2:2, 2 YCbCr 4:4:4) and every other bit 0.
- R5: Payload byte 2 has bits 5:4 equal to `aspect_sel` (1 for 4:3, 2 for 16:9), bits 3:0 equal to 8 (same as picture) and bits 7:6 zero; 16:9 gives 0x28.
- R6: Payload byte 4 equals `vic`; payload bytes 3 and 5 to 13 are zero.
- R7: With `tx_mode` = 2, each `vsync_pulse` seen while idle starts a packet; `tx_valid` is 1 in the cycle after the strobe.
- R8: With `tx_mode` = 0 or 3, `vsync_pulse` is ignored and no byte is offered.
- R9: With `tx_mode` = 1, only the first strobe after the mode becomes 1 (or after reset) starts a packet; later strobes are ignored until the mode leaves 1 and returns.
- R10: While `tx_valid` is 1 and `tx_ready` is 0, `tx_valid` and `tx_data` hold.
- R11: `vic`, `aspect_sel` and `colour_sel` are captured when a packet starts; changing them during a packet changes only later packets.
- R12: A strobe that would start a packet while one is in progress is dropped, the packet in flight continues unchanged, and `overflow` becomes 1 and stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| vsync_pulse | input | 1 | One-cycle frame-start strobe |
| tx_mode | input | 2 | Send mode: 0 off, 1 once, 2 every frame, 3 off |
| vic | input | 8 | Video timing identification code |
| aspect_sel | input | 2 | Picture aspect code |
| colour_sel | input | 2 | Colour encoding code |
| tx_ready | input | 1 | Downstream accepts the current byte |
| tx_valid | output | 1 | A packet byte is offered |
| tx_data | output | 8 | Packet byte |
| tx_last | output | 1 | Final byte of the packet |
| overflow | output | 1 | Sticky: a send request was dropped |

## Verification
The hardest situation to reach is a frame strobe landing while a packet is still in flight, since a packet normally drains in 17 cycles. The bench stretches a packet by holding `tx_ready` low for several cycles per byte and fires the strobe from a parallel thread in the middle, then checks that the packet arrives intact, that no second packet follows and that the flag stays set. Input capture is reached the same way: the configuration is changed under a stalled packet and the next packet must show the new values.

// File: rtl/avi_pkg.sv
// Shared constants and types for the video info packet generator.
// Assumes a fixed packet layout: header, one check byte, then payload.
package avi_pkg;
    localparam int HDR_LEN     = 3;
    localparam int PAYLOAD_LEN = 13;
    localparam int PKT_LEN     = HDR_LEN + 1 + PAYLOAD_LEN;
    localparam int IDX_W       = $clog2(PKT_LEN);
    localparam int CSUM_POS    = HDR_LEN;

    localparam logic [7:0] PKT_TYPE = 8'h82;
    localparam logic [7:0] PKT_VER  = 8'h02;

    typedef enum logic [1:0] {
        TXM_OFF   = 2'd0,
        TXM_ONCE  = 2'd1,
        TXM_EVERY = 2'd2,
        TXM_RSVD  = 2'd3
    } txm_e;

    typedef struct packed {
        logic [7:0] vic;
        logic [1:0] aspect;
        logic [1:0] colour;
    } avi_cfg_t;
endpackage

// File: rtl/avi_cfg_reg.sv
// Holds the packet configuration for the duration of one packet.
// Assumes load is a single-cycle strobe issued only when a packet starts.
module avi_cfg_reg
    import avi_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     load,
    input  avi_cfg_t cfg_d,
    output avi_cfg_t cfg_q
);
    // Capture the live configuration at packet start.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cfg_q <= '0;
        else if (load)
            cfg_q <= cfg_d;
    end
endmodule

// File: rtl/avi_byte_pack.sv
// Maps a byte index to the packet byte for a given configuration and
// computes the check byte so that all bytes sum to zero modulo 256.
// Assumes idx is below PKT_LEN whenever the output is used.
module avi_byte_pack
    import avi_pkg::*;
(
    input  avi_cfg_t         cfg,
    input  logic [IDX_W-1:0] idx,
    output logic [7:0]       byte_o
);
    localparam logic [7:0] PKT_LENGTH = 8'(PAYLOAD_LEN);

    logic [7:0] hdr [HDR_LEN];
    logic [7:0] pay [PAYLOAD_LEN];
    logic [7:0] sum8;
    logic [7:0] csum;
    logic [IDX_W-1:0] pay_idx;

    assign hdr[0] = PKT_TYPE;
    assign hdr[1] = PKT_VER;
    assign hdr[2] = PKT_LENGTH;

    // Payload field placement, one byte per generate iteration.
    genvar g;
    generate
        for (g = 0; g < PAYLOAD_LEN; g++) begin : g_pay
            if (g == 0) begin : g_fmt
                assign pay[g] = {1'b0, cfg.colour, 1'b1, 2'b00, 1'b1, 1'b0};
            end else if (g == 1) begin : g_asp
                assign pay[g] = {2'b00, cfg.aspect, 4'h8};
            end else if (g == 3) begin : g_vic
                assign pay[g] = cfg.vic;
            end else begin : g_zero
                assign pay[g] = 8'h00;
            end
        end
    endgenerate

    // Modulo-256 sum of header and payload.
    always_comb begin
        sum8 = 8'h00;
        for (int i = 0; i < HDR_LEN; i++)
            sum8 = sum8 + hdr[i];
        for (int j = 0; j < PAYLOAD_LEN; j++)
            sum8 = sum8 + pay[j];
    end

    assign csum    = 8'h00 - sum8;
    assign pay_idx = idx - IDX_W'(CSUM_POS + 1);

    // Select the byte for the current position.
    always_comb begin
        if (idx < IDX_W'(HDR_LEN))
            byte_o = hdr[idx[1:0]];
        else if (idx == IDX_W'(CSUM_POS))
            byte_o = csum;
        else if (pay_idx < IDX_W'(PAYLOAD_LEN))
            byte_o = pay[pay_idx];
        else
            byte_o = 8'h00;
    end
endmodule

// File: rtl/avi_tx_seq.sv
// Decides when a packet starts, walks the byte index under the
// valid/ready handshake and records dropped send requests.
// Assumes vsync is a one-cycle strobe and mode is a steady control.
module avi_tx_seq
    import avi_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             vsync,
    input  logic [1:0]       mode,
    input  logic             ready,
    output logic             busy,
    output logic [IDX_W-1:0] idx,
    output logic             last,
    output logic             load,
    output logic             overflow
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(PKT_LEN - 1);

    logic once_done;
    logic want;

    // Whether a strobe in the current mode asks for a packet.
    always_comb begin
        case (txm_e'(mode))
            TXM_EVERY: want = 1'b1;
            TXM_ONCE:  want = !once_done;
            default:   want = 1'b0;
        endcase
    end

    assign load = vsync && want && !busy;
    assign last = busy && (idx == LAST_IDX);

    // Packet-in-flight flag and byte position.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            idx  <= '0;
        end else if (load) begin
            busy <= 1'b1;
            idx  <= '0;
        end else if (busy && ready) begin
            if (last) begin
                busy <= 1'b0;
                idx  <= '0;
            end else begin
                idx <= idx + 1'b1;
            end
        end
    end

    // One-shot tracking: rearmed whenever the mode is not "once".
    always_ff @(posedge clk) begin
        if (!rst_n)
            once_done <= 1'b0;
        else if (txm_e'(mode) != TXM_ONCE)
            once_done <= 1'b0;
        else if (load)
            once_done <= 1'b1;
    end

    // Sticky record of a request lost to a packet in flight.
    always_ff @(posedge clk) begin
        if (!rst_n)
            overflow <= 1'b0;
        else if (vsync && want && busy)
            overflow <= 1'b1;
    end

    assert_idx_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> idx <= LAST_IDX);

    assert_end_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && ready && last) |=> !busy);

    assert_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && vsync && mode == 2'd2) |=> (busy && idx == '0));

    assert_off_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && (mode == 2'd0 || mode == 2'd3)) |=> !busy);

    assert_hold_idx_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !ready) |=> (busy && idx == $past(idx)));

    assert_drop_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && vsync && mode == 2'd2) |=> overflow);

    assert_sticky_R12: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |=> overflow);
endmodule

// File: rtl/avi_pkt_gen.sv
// Video info packet generator top: captures the configuration at
// packet start and streams the 17-byte packet over valid/ready.
// Assumes the downstream sink keeps tx_ready meaningful every cycle.
module avi_pkt_gen
    import avi_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       vsync_pulse,
    input  logic [1:0] tx_mode,
    input  logic [7:0] vic,
    input  logic [1:0] aspect_sel,
    input  logic [1:0] colour_sel,
    input  logic       tx_ready,
    output logic       tx_valid,
    output logic [7:0] tx_data,
    output logic       tx_last,
    output logic       overflow
);
    avi_cfg_t         cfg_live;
    avi_cfg_t         cfg_held;
    logic             load;
    logic             busy;
    logic [IDX_W-1:0] idx;

    assign cfg_live = '{vic: vic, aspect: aspect_sel, colour: colour_sel};

    avi_tx_seq u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .vsync    (vsync_pulse),
        .mode     (tx_mode),
        .ready    (tx_ready),
        .busy     (busy),
        .idx      (idx),
        .last     (tx_last),
        .load     (load),
        .overflow (overflow)
    );

    avi_cfg_reg u_cfg (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (load),
        .cfg_d (cfg_live),
        .cfg_q (cfg_held)
    );

    avi_byte_pack u_pack (
        .cfg    (cfg_held),
        .idx    (idx),
        .byte_o (tx_data)
    );

    assign tx_valid = busy;

    assert_reset_R1: assert property (@(posedge clk)
        !rst_n |=> (!tx_valid && !overflow));

    assert_stall_data_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));

    assert_first_byte_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_valid) |-> tx_data == PKT_TYPE);
endmodule

// File: tb/avi_pkt_gen_test.sv
module avi_pkt_gen_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       vsync_pulse = 1'b0;
    logic [1:0] tx_mode = 2'd0;
    logic [7:0] vic = 8'd16;
    logic [1:0] aspect_sel = 2'd2;
    logic [1:0] colour_sel = 2'd0;
    logic       tx_ready = 1'b0;
    logic       tx_valid;
    logic [7:0] tx_data;
    logic       tx_last;
    logic       overflow;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    logic [7:0] pk [17];

    always #2.5 clk = ~clk;

    avi_pkt_gen uut (
        .clk(clk), .rst_n(rst_n), .vsync_pulse(vsync_pulse), .tx_mode(tx_mode),
        .vic(vic), .aspect_sel(aspect_sel), .colour_sel(colour_sel),
        .tx_ready(tx_ready), .tx_valid(tx_valid), .tx_data(tx_data),
        .tx_last(tx_last), .overflow(overflow)
    );

    // Watchdog: a hung run counts as a failure.
    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 100000) begin
                errors++;
                checks++;
                $display("FAIL watchdog: act=%0d exp<100000 cycles", cyc);
                $display("Result: errors=%0d of %0d checks", errors, checks);
                $finish;
            end
        end
    end

    task automatic check(input logic ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: act=0x%0h exp=0x%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_byte(input int i, input logic [7:0] v,
                                            input logic [1:0] a, input logic [1:0] c);
        logic [7:0] s;
        logic [7:0] b [17];
        b[0] = 8'h82; b[1] = 8'h02; b[2] = 8'h0D; b[3] = 8'h00;
        for (int k = 4; k < 17; k++) b[k] = 8'h00;
        b[4] = 8'h12 | (8'(c) << 5);
        b[5] = (8'(a) << 4) | 8'h08;
        b[7] = v;
        s = 8'h00;
        for (int k = 0; k < 17; k++) s = s + b[k];
        b[3] = 8'h00 - s;
        return b[i];
    endfunction

    task automatic pulse_vsync();
        @(negedge clk); vsync_pulse = 1'b1;
        @(negedge clk); vsync_pulse = 1'b0;
    endtask

    // Receive one packet; stall holds ready low this many cycles per byte.
    task automatic recv_packet(input int stall, input string req);
        int n = 0;
        int waited = 0;
        int sc = 0;
        logic bad_hold = 1'b0;
        logic bad_last = 1'b0;
        logic [7:0] held = 8'h00;
        while (n < 17 && waited < 1000) begin
            @(negedge clk);
            waited++;
            if (tx_valid) begin
                if (sc < stall) begin
                    tx_ready = 1'b0;
                    if (sc > 0 && tx_data != held) bad_hold = 1'b1;
                    held = tx_data;
                    sc++;
                end else begin
                    if (sc > 0 && tx_data != held) bad_hold = 1'b1;
                    tx_ready = 1'b1;
                    pk[n] = tx_data;
                    if (tx_last != (n == 16)) bad_last = 1'b1;
                    n++;
                    sc = 0;
                end
            end else begin
                tx_ready = 1'b0;
            end
        end
        @(negedge clk);
        tx_ready = 1'b0;
        check(n == 17, {req, " byte count"}, n, 17);
        check(!bad_last, "R2 tx_last only on byte 17", bad_last, 0);
        if (stall > 0) check(!bad_hold, "R10 data held under stall", bad_hold, 0);
        check(!tx_valid, "R2 valid drops after last", tx_valid, 0);
    endtask

    task automatic cmp_packet(input string req, input logic [7:0] v,
                              input logic [1:0] a, input logic [1:0] c);
        int bad = -1;
        logic [7:0] s = 8'h00;
        for (int i = 16; i >= 0; i--) begin
            if (pk[i] != exp_byte(i, v, a, c)) bad = i;
            s = s + pk[i];
        end
        check(bad < 0, {req, " packet bytes"}, bad < 0 ? 0 : int'(pk[bad]),
              bad < 0 ? 0 : int'(exp_byte(bad, v, a, c)));
        check(s == 8'h00, "R3 byte sum zero", s, 0);
    endtask

    task automatic quiet(input int n, input string req);
        logic seen = 1'b0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (tx_valid) seen = 1'b1;
        end
        check(!seen, req, seen, 0);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check(!tx_valid && !tx_last, "R1 valid/last after reset", tx_valid, 0);
        check(!overflow, "R1 overflow after reset", overflow, 0);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_basic();
        tx_mode = 2'd2; vic = 8'd16; aspect_sel = 2'd2; colour_sel = 2'd0;
        @(negedge clk); vsync_pulse = 1'b1;
        @(negedge clk); vsync_pulse = 1'b0;
        check(tx_valid, "R7 valid the cycle after strobe", tx_valid, 1);
        recv_packet(0, "R2");
        check(pk[0] == 8'h82 && pk[1] == 8'h02 && pk[2] == 8'h0D, "R2 header",
              {pk[0], pk[1], pk[2]}, 24'h82020D);
        check(pk[3] == 8'h25, "R3 check byte 1080p 16:9 RGB", pk[3], 8'h25);
        check(pk[4] == 8'h12, "R4 payload byte 1 RGB", pk[4], 8'h12);
        check(pk[5] == 8'h28, "R5 payload byte 2 16:9", pk[5], 8'h28);
        check(pk[7] == 8'd16 && pk[6] == 8'h00 && pk[16] == 8'h00, "R6 code and zero bytes",
              pk[7], 16);
        cmp_packet("R2", 8'd16, 2'd2, 2'd0);
        pulse_vsync();
        recv_packet(0, "R7 second frame");
        cmp_packet("R7", 8'd16, 2'd2, 2'd0);
    endtask

    task automatic t_stall_variant();
        vic = 8'd4; aspect_sel = 2'd1; colour_sel = 2'd2;
        pulse_vsync();
        recv_packet(3, "R10");
        check(pk[4] == 8'h52, "R4 payload byte 1 YCbCr444", pk[4], 8'h52);
        check(pk[5] == 8'h18, "R5 payload byte 2 4:3", pk[5], 8'h18);
        cmp_packet("R6", 8'd4, 2'd1, 2'd2);
    endtask

    task automatic t_off_modes();
        tx_mode = 2'd0;
        pulse_vsync();
        quiet(6, "R8 mode 0 ignores strobe");
        tx_mode = 2'd3;
        pulse_vsync();
        quiet(6, "R8 mode 3 ignores strobe");
    endtask

    task automatic t_once();
        vic = 8'd16; aspect_sel = 2'd2; colour_sel = 2'd1;
        tx_mode = 2'd1;
        @(negedge clk);
        pulse_vsync();
        recv_packet(0, "R9 first strobe");
        cmp_packet("R9", 8'd16, 2'd2, 2'd1);
        pulse_vsync();
        quiet(6, "R9 second strobe ignored");
        tx_mode = 2'd0;
        @(negedge clk);
        tx_mode = 2'd1;
        pulse_vsync();
        recv_packet(0, "R9 rearmed");
    endtask

    task automatic t_capture();
        tx_mode = 2'd2; vic = 8'd31; aspect_sel = 2'd2; colour_sel = 2'd0;
        pulse_vsync();
        fork
            recv_packet(2, "R11");
            begin
                repeat (3) @(negedge clk);
                vic = 8'd2; aspect_sel = 2'd1; colour_sel = 2'd1;
            end
        join
        cmp_packet("R11 old config kept", 8'd31, 2'd2, 2'd0);
        pulse_vsync();
        recv_packet(0, "R11 next");
        cmp_packet("R11 new config used", 8'd2, 2'd1, 2'd1);
    endtask

    task automatic t_overflow();
        vic = 8'd16; aspect_sel = 2'd2; colour_sel = 2'd0; tx_mode = 2'd2;
        check(!overflow, "R12 no overflow before collision", overflow, 0);
        pulse_vsync();
        fork
            recv_packet(3, "R12");
            begin
                repeat (10) @(negedge clk);
                vsync_pulse = 1'b1;
                @(negedge clk);
                vsync_pulse = 1'b0;
            end
        join
        cmp_packet("R12 packet intact", 8'd16, 2'd2, 2'd0);
        quiet(8, "R12 dropped request makes no packet");
        check(overflow, "R12 overflow set", overflow, 1);
        pulse_vsync();
        recv_packet(0, "R12 later packet");
        check(overflow, "R12 overflow sticky", overflow, 1);
    endtask

    initial begin
        t_reset();
        t_basic();
        t_stall_variant();
        t_off_modes();
        t_once();
        t_capture();
        t_overflow();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule